// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Keeper with Alarm

This block keeps wall-clock time and a calendar: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Software reaches all of it through one synchronous indexed port. A write strobe stores a byte at an index, and the read data shows the byte at the current index with no clock delay. Once per second an external one-second tick starts an update. A status flag, `uip`, rises first. A programmable number of fast clock-enable pulses later, the counters advance by one second and carry through the calendar. The flag then stays high for a second programmable hold period. Software that sees the flag low therefore has a safe window to read a consistent time.

The time bytes are held in the encoding that software has chosen in a control byte. That encoding is either packed BCD or plain binary, with hours in either 24-hour form or 12-hour form. In 12-hour form, bit 7 of the hours byte marks the afternoon. Three alarm bytes are compared with seconds, minutes and hours right after each advance, and a full match gives a one-cycle alarm pulse. An alarm byte whose two top bits are both 1 matches any value. A halt bit in the control byte freezes the advance so that software can load a new time.

Top module: `rtc_calendar`

## Requirements
- R1: Index map: seconds 0, seconds alarm 1, minutes 2, minutes alarm 3, hours 4, hours alarm 5, weekday 6, day of month 7, month 8, year 9, status 10, control 11. After reset the weekday, day and month read 1, control reads 0x02, and every other index reads 0.
- R2: `uip` and status bit 7 rise one cycle after a `sec_tick` accepted while idle. With `fast_en` held high, the time bytes change LEAD_TICKS+1 cycles after the tick edge, and not before.
- R3: With `fast_en` held high, `uip` falls LEAD_TICKS+HOLD_TICKS+2 cycles after the tick edge.
- R4: In BCD mode (control bit 2 = 0), seconds and minutes wrap from 0x59 to 0x00. In 24-hour mode (control bit 1 = 1), hours wrap from 0x23 to 0x00, and each wrap carries into the next field.
- R5: In binary mode (control bit 2 = 1), every time byte counts in plain binary, e.g. seconds 59 becomes 0 and minutes 9 becomes 10.
- R6: A day carry wraps the day of month to 1 after the month's last day. That last day is 30 in months 4, 6, 9 and 11, 29 in month 2 when year mod 4 = 0, 28 in month 2 otherwise, and 31 in all other months. Month wraps 12 to 1, year wraps 99 to 0, and weekday wraps 7 to 1.
- R7: In 12-hour mode (control bit 1 = 0), hours run 1 to 12 with bit 7 = PM. 11 AM goes to 12 PM (0x92 in BCD), 11 PM goes to 12 AM (0x12) with a day carry, and 12 AM goes to 1 AM.
- R8: `alarm_pulse` is high for exactly one cycle, the cycle right after the time bytes change, when seconds, minutes and hours each equal their alarm byte. There is no pulse when any field differs.
- R9: An alarm byte with bits 7 and 6 both set matches every value of its field.
- R10: While control bit 7 is 1, `sec_tick` is ignored, `uip` stays low and the time bytes keep what software writes.
- R11: Writes to the status index change nothing. Status bits 6..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second that starts an update |
| fast_en | input | 1 | Clock enable that paces the lead and hold counts |
| wr_en | input | 1 | Write strobe for the indexed port |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the indexed register, combinational |
| uip | output | 1 | Update in progress |
| alarm_pulse | output | 1 | One-cycle alarm match event |

## Verification
Read data is combinational, and a write lands at the next edge, so the bench reads at the falling edge after a write. The bench counts falling edges after the edge that took `sec_tick`. With `fast_en` high and the bench's lead of 3 and hold of 4, `uip` must read high at count 0, the watched byte and `alarm_pulse` must first change at count 4, and `uip` must fall at count 9. Every update scenario samples at those exact counts and records the first count at which each event shows. Calendar results are read back only after `uip` has fallen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [6:0]        num_t;

   localparam int IX_SEC   = 0;
   localparam int IX_ASEC  = 1;
   localparam int IX_MIN   = 2;
   localparam int IX_AMIN  = 3;
   localparam int IX_HR    = 4;
   localparam int IX_AHR   = 5;
   localparam int IX_WDAY  = 6;
   localparam int IX_MDAY  = 7;
   localparam int IX_MON   = 8;
   localparam int IX_YEAR  = 9;
   localparam int IX_STAT  = 10;
   localparam int IX_CTRL  = 11;
   localparam int NUM_TIME = 10;

   localparam int CB_HALT = 7;
   localparam int CB_BIN  = 2;
   localparam int CB_H24  = 1;
   localparam byte_t CTRL_RESET = 8'h02;

   function automatic num_t to_num(byte_t v, logic bin);
      if (bin) return v[6:0];
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic byte_t to_byte(num_t n, logic bin);
      if (bin) return {1'b0, n};
      return {4'(n / 7'd10), 4'(n % 7'd10)};
   endfunction

   function automatic num_t hour_to24(byte_t h, logic bin, logic h24);
      num_t b;
      if (h24) return to_num(h, bin);
      b = to_num({1'b0, h[6:0]}, bin);
      if (b == 7'd12) b = 7'd0;
      if (h[7]) b = b + 7'd12;
      return b;
   endfunction

   function automatic byte_t hour_from24(num_t n, logic bin, logic h24);
      num_t  b;
      byte_t r;
      logic  pm;
      if (h24) return to_byte(n, bin);
      pm = (n >= 7'd12);
      b  = pm ? n - 7'd12 : n;
      if (b == 7'd0) b = 7'd12;
      r    = to_byte(b, bin);
      r[7] = pm;
      return r;
   endfunction

   function automatic num_t last_day(num_t mo, logic leap);
      case (mo)
         7'd2:                       return leap ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
         default:                    return 7'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq
   import rtc_pkg::*;
#(
   parameter int LEAD_TICKS = 8,
   parameter int HOLD_TICKS = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fast_en,
   input  logic halt,
   output logic busy,
   output logic commit,
   output logic check
);
   localparam int MAXT  = (LEAD_TICKS > HOLD_TICKS) ? LEAD_TICKS : HOLD_TICKS;
   localparam int CNT_W = $clog2(MAXT + 1);
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

   initial begin
      assert (LEAD_TICKS >= 1) else $error("rtc_seq: LEAD_TICKS must be at least 1");
      assert (HOLD_TICKS >= 1) else $error("rtc_seq: HOLD_TICKS must be at least 1");
   end

   typedef enum logic [2:0] {S_IDLE, S_LEAD, S_COMMIT, S_CHECK, S_HOLD} st_t;
   st_t              st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (tick && !halt) begin
               st_q  <= S_LEAD;
               cnt_q <= '0;
            end
            S_LEAD: if (fast_en) begin
               if (cnt_q == LEAD_LAST) st_q <= S_COMMIT;
               else                    cnt_q <= cnt_q + 1'b1;
            end
            S_COMMIT: st_q <= S_CHECK;
            S_CHECK: begin
               st_q  <= S_HOLD;
               cnt_q <= '0;
            end
            S_HOLD: if (fast_en) begin
               if (cnt_q == HOLD_LAST) st_q <= S_IDLE;
               else                    cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != S_IDLE);
   assign commit = (st_q == S_COMMIT);
   assign check  = (st_q == S_CHECK);

   // R2: the advance never comes without the flag having been up beforehand
   a_r2_lead_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(busy));
   // R3: the flag can only drop out of the hold phase, never right after the advance
   a_r3_hold_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy);
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
   import rtc_pkg::*;
(
   input  byte_t sec_i,
   input  byte_t min_i,
   input  byte_t hr_i,
   input  byte_t wday_i,
   input  byte_t mday_i,
   input  byte_t mon_i,
   input  byte_t year_i,
   input  logic  bin,
   input  logic  h24,
   output byte_t sec_o,
   output byte_t min_o,
   output byte_t hr_o,
   output byte_t wday_o,
   output byte_t mday_o,
   output byte_t mon_o,
   output byte_t year_o
);
   num_t s, m, h, w, d, mo, y, dlast;
   logic c_s, c_m, c_h, c_d, c_mo;

   always_comb begin
      s  = to_num(sec_i, bin);
      m  = to_num(min_i, bin);
      h  = hour_to24(hr_i, bin, h24);
      w  = to_num(wday_i, bin);
      d  = to_num(mday_i, bin);
      mo = to_num(mon_i, bin);
      y  = to_num(year_i, bin);
      dlast = last_day(mo, (y[1:0] == 2'b00));

      c_s  = (s >= 7'd59);
      c_m  = c_s && (m >= 7'd59);
      c_h  = c_m && (h >= 7'd23);
      c_d  = c_h && (d >= dlast);
      c_mo = c_d && (mo >= 7'd12);

      sec_o  = to_byte(c_s ? 7'd0 : s + 7'd1, bin);
      min_o  = c_s ? to_byte((m >= 7'd59) ? 7'd0 : m + 7'd1, bin) : min_i;
      hr_o   = c_m ? hour_from24((h >= 7'd23) ? 7'd0 : h + 7'd1, bin, h24) : hr_i;
      wday_o = c_h ? to_byte((w >= 7'd7) ? 7'd1 : w + 7'd1, bin) : wday_i;
      mday_o = c_h ? to_byte(c_d ? 7'd1 : d + 7'd1, bin) : mday_i;
      mon_o  = c_d ? to_byte(c_mo ? 7'd1 : mo + 7'd1, bin) : mon_i;
      year_o = c_mo ? to_byte((y >= 7'd99) ? 7'd0 : y + 7'd1, bin) : year_i;
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_pkg::*;
#(
   parameter int NUM_FIELDS = 3,
   parameter bit WILDCARD   = 1'b1
) (
   input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur,
   input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm,
   output logic                              all_hit
);
   initial begin
      assert (NUM_FIELDS >= 1) else $error("rtc_alarm_cmp: NUM_FIELDS must be at least 1");
   end

   logic [NUM_FIELDS-1:0] hit;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      if (WILDCARD) begin : g_wild
         assign hit[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
      end else begin : g_exact
         assign hit[i] = (alm[i] == cur[i]);
      end
   end

   assign all_hit = &hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int LEAD_TICKS = 8,
   parameter int HOLD_TICKS = 65,
   parameter bit WILDCARD   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       fast_en,
   input  logic       wr_en,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       uip,
   output logic       alarm_pulse
);
   byte_t tq [NUM_TIME];
   byte_t ctrl_q;
   logic  commit, check, hit;
   byte_t n_sec, n_min, n_hr, n_wday, n_mday, n_mon, n_year;

   rtc_seq #(.LEAD_TICKS(LEAD_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .fast_en(fast_en),
      .halt(ctrl_q[CB_HALT]), .busy(uip), .commit(commit), .check(check)
   );

   rtc_advance u_adv (
      .sec_i(tq[IX_SEC]), .min_i(tq[IX_MIN]), .hr_i(tq[IX_HR]),
      .wday_i(tq[IX_WDAY]), .mday_i(tq[IX_MDAY]), .mon_i(tq[IX_MON]),
      .year_i(tq[IX_YEAR]), .bin(ctrl_q[CB_BIN]), .h24(ctrl_q[CB_H24]),
      .sec_o(n_sec), .min_o(n_min), .hr_o(n_hr), .wday_o(n_wday),
      .mday_o(n_mday), .mon_o(n_mon), .year_o(n_year)
   );

   rtc_alarm_cmp #(.NUM_FIELDS(3), .WILDCARD(WILDCARD)) u_alm (
      .cur({tq[IX_HR], tq[IX_MIN], tq[IX_SEC]}),
      .alm({tq[IX_AHR], tq[IX_AMIN], tq[IX_ASEC]}),
      .all_hit(hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_TIME; i++) tq[i] <= '0;
         tq[IX_WDAY] <= 8'h01;
         tq[IX_MDAY] <= 8'h01;
         tq[IX_MON]  <= 8'h01;
         ctrl_q      <= CTRL_RESET;
      end else begin
         if (commit && !ctrl_q[CB_HALT]) begin
            tq[IX_SEC]  <= n_sec;
            tq[IX_MIN]  <= n_min;
            tq[IX_HR]   <= n_hr;
            tq[IX_WDAY] <= n_wday;
            tq[IX_MDAY] <= n_mday;
            tq[IX_MON]  <= n_mon;
            tq[IX_YEAR] <= n_year;
         end
         if (wr_en) begin
            if (int'(addr) < NUM_TIME) tq[addr] <= wdata;
            else if (int'(addr) == IX_CTRL) ctrl_q <= wdata;
         end
      end
   end

   always_comb begin
      if (int'(addr) < NUM_TIME)      rdata = tq[addr];
      else if (int'(addr) == IX_STAT) rdata = {uip, 7'd0};
      else if (int'(addr) == IX_CTRL) rdata = ctrl_q;
      else                            rdata = '0;
   end

   assign alarm_pulse = check && hit;

   // R2: seconds byte moves only by an advance or a software write
   a_r2_sec_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !wr_en) |=> $stable(tq[IX_SEC]));
   // R8: the alarm event is a single-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |=> !alarm_pulse);
   // R8: the alarm event only appears inside an update window
   a_r8_pulse_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> uip);
   // R10: with the halt bit set, an idle keeper stays idle
   a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_HALT] && !uip) |=> !uip);
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEAD = 3;
   localparam int HOLD = 4;
   localparam int K_CHG  = LEAD + 1;
   localparam int K_FALL = LEAD + HOLD + 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       fast_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       uip, alarm_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   rtc_calendar #(.LEAD_TICKS(LEAD), .HOLD_TICKS(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .fast_en(fast_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .uip(uip), .alarm_pulse(alarm_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      addr = 4'(a);
      #1;
      v = int'(rdata);
   endtask

   task automatic expect_rd(string req, int a, int exp);
      int v;
      rd(a, v);
      chk(req, $sformatf("index %0d", a), v, exp);
   endtask

   task automatic set_time(int ctrl, int hr, int mn, int sc);
      wr(11, ctrl); wr(4, hr); wr(2, mn); wr(0, sc);
   endtask

   task automatic set_date(int wd, int md, int mo, int yr);
      wr(6, wd); wr(7, md); wr(8, mo); wr(9, yr);
   endtask

   // runs one update watching seconds; returns when uip has fallen
   task automatic run_update(output int chg_at, output int alm_cnt,
                             output int alm_at, output int fall_at,
                             output int uip0);
      int v0;
      chg_at = -1; alm_cnt = 0; alm_at = -1; fall_at = -1;
      rd(0, v0);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      uip0 = int'(uip);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (int'(rdata) != v0 && chg_at < 0) chg_at = k;
         if (alarm_pulse) begin
            alm_cnt++;
            if (alm_at < 0) alm_at = k;
         end
         if (!uip && fall_at < 0) fall_at = k;
      end
   endtask

   task automatic simple_update();
      int c, n, a, f, u;
      run_update(c, n, a, f, u);
   endtask

   task automatic t_reset();
      expect_rd("R1", 0, 8'h00); expect_rd("R1", 2, 8'h00);
      expect_rd("R1", 4, 8'h00); expect_rd("R1", 1, 8'h00);
      expect_rd("R1", 6, 8'h01); expect_rd("R1", 7, 8'h01);
      expect_rd("R1", 8, 8'h01); expect_rd("R1", 9, 8'h00);
      expect_rd("R1", 10, 8'h00); expect_rd("R1", 11, 8'h02);
      chk("R1", "uip", int'(uip), 0);
   endtask

   task automatic t_timing();
      int c, n, a, f, u, s;
      set_time(8'h02, 8'h01, 8'h02, 8'h03);
      wr(1, 8'h00);
      run_update(c, n, a, f, u);
      chk("R2", "uip after tick", u, 1);
      chk("R2", "change cycle", c, K_CHG);
      chk("R3", "uip fall cycle", f, K_FALL);
      chk("R8", "no alarm on mismatch", n, 0);
      rd(0, s);
      chk("R4", "seconds +1", s, 8'h04);
   endtask

   task automatic t_status_flag();
      int v;
      addr = 4'd10;
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      #1 v = int'(rdata);
      chk("R2", "status bit7 in update", v, 8'h80);
      repeat (K_FALL + 2) @(negedge clk);
      expect_rd("R11", 10, 8'h00);
   endtask

   task automatic t_bcd_wrap();
      set_time(8'h02, 8'h23, 8'h59, 8'h59);
      set_date(8'h07, 8'h31, 8'h12, 8'h99);
      simple_update();
      expect_rd("R4", 0, 8'h00); expect_rd("R4", 2, 8'h00);
      expect_rd("R4", 4, 8'h00);
      expect_rd("R6", 6, 8'h01); expect_rd("R6", 7, 8'h01);
      expect_rd("R6", 8, 8'h01); expect_rd("R6", 9, 8'h00);
   endtask

   task automatic t_binary();
      set_time(8'h06, 8'd5, 8'd9, 8'd59);
      simple_update();
      expect_rd("R5", 0, 0); expect_rd("R5", 2, 10); expect_rd("R5", 4, 5);
      set_time(8'h06, 8'd23, 8'd59, 8'd59);
      set_date(3, 28, 2, 24);
      simple_update();
      expect_rd("R6", 7, 29); expect_rd("R6", 8, 2); expect_rd("R6", 6, 4);
      set_time(8'h06, 8'd23, 8'd59, 8'd59);
      simple_update();
      expect_rd("R6", 7, 1); expect_rd("R6", 8, 3);
      set_time(8'h06, 8'd23, 8'd59, 8'd59);
      set_date(3, 28, 2, 23);
      simple_update();
      expect_rd("R6", 7, 1); expect_rd("R6", 8, 3);
   endtask

   task automatic t_month30();
      set_time(8'h02, 8'h23, 8'h59, 8'h59);
      set_date(8'h02, 8'h30, 8'h04, 8'h10);
      simple_update();
      expect_rd("R6", 7, 8'h01); expect_rd("R6", 8, 8'h05);
   endtask

   task automatic t_12h();
      set_time(8'h00, 8'h11, 8'h59, 8'h59);
      simple_update();
      expect_rd("R7", 4, 8'h92);
      set_time(8'h00, 8'h91, 8'h59, 8'h59);
      set_date(8'h02, 8'h05, 8'h06, 8'h10);
      simple_update();
      expect_rd("R7", 4, 8'h12); expect_rd("R7", 7, 8'h06);
      set_time(8'h00, 8'h12, 8'h59, 8'h59);
      simple_update();
      expect_rd("R7", 4, 8'h01);
   endtask

   task automatic t_alarm();
      int c, n, a, f, u;
      set_time(8'h02, 8'h10, 8'h20, 8'h29);
      wr(1, 8'h30); wr(3, 8'h20); wr(5, 8'h10);
      run_update(c, n, a, f, u);
      chk("R8", "pulse count on match", n, 1);
      chk("R8", "pulse cycle", a, K_CHG);
      wr(1, 8'h45);
      run_update(c, n, a, f, u);
      chk("R8", "no pulse on seconds miss", n, 0);
      wr(1, 8'hC0); wr(3, 8'hC0); wr(5, 8'hC0);
      run_update(c, n, a, f, u);
      chk("R9", "all wildcard pulse", n, 1);
      wr(3, 8'h20); wr(5, 8'h10);
      run_update(c, n, a, f, u);
      chk("R9", "seconds wildcard pulse", n, 1);
      wr(5, 8'h11);
      run_update(c, n, a, f, u);
      chk("R9", "wildcard with hour miss", n, 0);
   endtask

   task automatic t_halt();
      int c, n, a, f, u;
      set_time(8'h82, 8'h05, 8'h06, 8'h07);
      run_update(c, n, a, f, u);
      chk("R10", "uip stays low", u, 0);
      chk("R10", "seconds unchanged", c, -1);
      wr(0, 8'h33);
      expect_rd("R10", 0, 8'h33);
      wr(11, 8'h02);
   endtask

   task automatic t_status_write();
      wr(0, 8'h21);
      wr(10, 8'hFF);
      expect_rd("R11", 10, 8'h00);
      expect_rd("R11", 0, 8'h21);
      expect_rd("R11", 11, 8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timing();
      t_status_flag();
      t_bcd_wrap();
      t_binary();
      t_month30();
      t_12h();
      t_alarm();
      t_halt();
      t_status_write();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule